// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This unit takes one IEEE-754 operand, either single precision (binary32) or double precision (binary64), and turns it into a signed two's-complement integer of 32 or 64 bits. The rounding direction is chosen for each operation. The four choices are nearest-even, toward zero, toward plus infinity and toward minus infinity. The unit keeps no rounding state between operations.

The unit raises three cause flags: invalid, overflow and inexact. A NaN, an infinity, or a finite value whose rounded result does not fit the destination range gives a fixed sentinel. The sentinel is the largest positive integer of the destination width, whatever the sign of the input. Subnormal inputs are converted at their true value and are not flushed.

A request is one cycle with `in_valid` high. The result and the flags appear on registered outputs on the next cycle, with `out_valid` high.

Top module: `f2i_convert`

## Requirements
- R1: Results and flags are registered. They appear one clock after a cycle with `in_valid` high, and `out_valid` is high in exactly that cycle. While `in_valid` is low, `result` and the flags hold their previous values.
- R2: The source format is selected by `fmt_dbl`. When it is 1, `operand[63:0]` is a binary64 value. When it is 0, `operand[31:0]` is a binary32 value and `operand[63:32]` has no effect on any output.
- R3: `dst_wide` = 1 gives a signed 64-bit result. `dst_wide` = 0 gives a signed 32-bit result in `result[31:0]`, and `result[63:32]` is zero.
- R4: The `rmode` encoding is 0 for nearest with ties to even, 1 for toward zero, 2 for toward plus infinity and 3 for toward minus infinity. Each operation uses only the mode given with it.
- R5: A NaN of either sign, or an infinity of either sign, sets `flag_invalid` and leaves `flag_overflow` clear.
- R6: A finite input whose rounded value falls outside the signed range of the destination sets both `flag_invalid` and `flag_overflow`.
- R7: Whenever `flag_invalid` is set, `result` is the sentinel, whatever the input sign. The sentinel is 0x7FFFFFFFFFFFFFFF for a 64-bit destination and 0x000000007FFFFFFF for a 32-bit destination.
- R8: `flag_inexact` is set when the input has a nonzero fractional part and the result is not the sentinel. It is never set together with `flag_invalid`.
- R9: A negative input that rounds to zero gives integer zero, and `flag_inexact` is set if any fraction was discarded.
- R10: The most negative destination value (-2^31 for 32 bits, -2^63 for 64 bits) converts exactly with no flags raised.
- R11: A synchronous active-high reset clears `out_valid`, `result` and all three flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A conversion request in this cycle |
| operand | input | 64 | Floating-point operand (binary32 in the low half) |
| fmt_dbl | input | 1 | 1 = binary64 source, 0 = binary32 source |
| dst_wide | input | 1 | 1 = 64-bit destination, 0 = 32-bit destination |
| rmode | input | 2 | Rounding direction for this operation |
| out_valid | output | 1 | The result of the previous cycle's request is present |
| result | output | 64 | Signed integer result or sentinel |
| flag_invalid | output | 1 | NaN, infinity or out-of-range input |
| flag_overflow | output | 1 | Finite input out of range |
| flag_inexact | output | 1 | Fraction discarded, no sentinel |

## Verification
The assertions check, on every cycle, the one-cycle valid timing, that outputs hold while idle, and that the upper half is zero for 32-bit results. They also check that any invalid result carries the sentinel, that overflow never appears without invalid and inexact never with it, and that all-ones exponents raise invalid only. The numerical value itself can only be shown by the bench's scenarios. These cover rounding of ties in every mode, negative fractions collapsing to zero, values one half-step below the range edge, exact conversion of the most negative integers, and junk in the unused upper half of a binary32 operand. A real-number reference model checks thousands of mixed vectors.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int SGL_W      = 1 + SGL_EXP_W + SGL_FRAC_W;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int DBL_W      = 1 + DBL_EXP_W + DBL_FRAC_W;
  localparam int SIG_W      = DBL_FRAC_W + 1;
  localparam int EXP_W      = DBL_EXP_W + 2;
  localparam int INT_W      = 64;
  localparam int NARROW_W   = 32;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'd0,
    RM_ZERO      = 2'd1,
    RM_POS       = 2'd2,
    RM_NEG       = 2'd3
  } rmode_e;

  // common form of either source format; sig has its unit bit at the top
  typedef struct packed {
    logic                    sign;
    logic                    is_nan;
    logic                    is_inf;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
  } unpacked_t;

  typedef struct packed {
    logic             sign;
    logic             special;
    logic             big;
    logic             inexact;
    logic [INT_W:0]   mag;
  } rounded_t;
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
#(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] bits,
  output unpacked_t      u
);
  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic [EW-1:0] e_fld;
  logic [FW-1:0] f_fld;
  logic          normal;

  assign e_fld  = bits[EW+FW-1:FW];
  assign f_fld  = bits[FW-1:0];
  assign normal = (e_fld != '0);

  always_comb begin
    u.sign   = bits[EW+FW];
    u.is_nan = (&e_fld) && (|f_fld);
    u.is_inf = (&e_fld) && !(|f_fld);
    if (normal) u.exp = EXP_W'(int'(e_fld) - BIAS);
    else        u.exp = EXP_W'(1 - BIAS);
    u.sig = SIG_W'({normal, f_fld}) << (SIG_W - 1 - FW);
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
(
  input  unpacked_t u,
  input  rmode_e    mode,
  output rounded_t  r
);
  localparam int FIX_W = 2 * INT_W;
  localparam int PAD_W = FIX_W - SIG_W;
  localparam int SH_W  = $clog2(FIX_W);
  localparam logic signed [EXP_W-1:0] E_MAX = EXP_W'(INT_W - 1);
  localparam logic signed [EXP_W-1:0] E_MIN = EXP_W'(-2);

  logic [FIX_W-1:0] fix;
  logic [INT_W-1:0] int_part;
  logic             far_sticky, half, sticky, up, big;

  always_comb begin
    fix        = '0;
    far_sticky = 1'b0;
    big        = 1'b0;
    if (u.exp > E_MAX)      big = 1'b1;
    else if (u.exp < E_MIN) far_sticky = |u.sig;
    else fix = {u.sig, {PAD_W{1'b0}}} >> SH_W'(E_MAX - u.exp);

    int_part = fix[FIX_W-1:INT_W];
    half     = fix[INT_W-1];
    sticky   = (|fix[INT_W-2:0]) | far_sticky;

    unique case (mode)
      RM_NEAR_EVEN: up = half & (sticky | int_part[0]);
      RM_ZERO:      up = 1'b0;
      RM_POS:       up = !u.sign & (half | sticky);
      RM_NEG:       up = u.sign & (half | sticky);
      default:      up = 1'b0;
    endcase

    r.sign    = u.sign;
    r.special = u.is_nan | u.is_inf;
    r.big     = big;
    r.inexact = half | sticky;
    r.mag     = {1'b0, int_part} + {{INT_W{1'b0}}, up};
  end
endmodule

// File: rtl/f2i_pack.sv
module f2i_pack
  import f2i_pkg::*;
(
  input  rounded_t         r,
  input  logic             dst_wide,
  output logic [INT_W-1:0] value,
  output logic             invalid,
  output logic             overflow,
  output logic             inexact
);
  logic [1:0]       oor;
  logic [INT_W-1:0] cand [2];
  logic [INT_W-1:0] twos;

  assign twos = r.sign ? (~r.mag[INT_W-1:0] + 1'b1) : r.mag[INT_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_dst
    localparam int W = (g == 0) ? NARROW_W : INT_W;
    localparam logic [INT_W:0] POS_MAX = {{(INT_W - W + 2){1'b0}}, {(W - 1){1'b1}}};
    localparam logic [INT_W:0] NEG_MAX = POS_MAX + 1;
    assign oor[g]  = r.big | (r.mag > (r.sign ? NEG_MAX : POS_MAX));
    assign cand[g] = (oor[g] | r.special) ? POS_MAX[INT_W-1:0] : INT_W'(twos[W-1:0]);
  end

  always_comb begin
    invalid  = r.special | oor[dst_wide];
    overflow = !r.special & oor[dst_wide];
    inexact  = r.inexact & !invalid;
    value    = cand[dst_wide];
  end
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
  import f2i_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DBL_W-1:0] operand,
  input  logic             fmt_dbl,
  input  logic             dst_wide,
  input  logic [1:0]       rmode,
  output logic             out_valid,
  output logic [INT_W-1:0] result,
  output logic             flag_invalid,
  output logic             flag_overflow,
  output logic             flag_inexact
);
  unpacked_t        unp_s, unp_d, unp;
  rounded_t         rnd;
  logic [INT_W-1:0] value;
  logic             inv_c, ovf_c, inx_c;

  f2i_unpack #(.EW(SGL_EXP_W), .FW(SGL_FRAC_W)) u_unp_s (
    .bits (operand[SGL_W-1:0]),
    .u    (unp_s)
  );

  f2i_unpack #(.EW(DBL_EXP_W), .FW(DBL_FRAC_W)) u_unp_d (
    .bits (operand),
    .u    (unp_d)
  );

  assign unp = fmt_dbl ? unp_d : unp_s;

  f2i_round u_round (
    .u    (unp),
    .mode (rmode_e'(rmode)),
    .r    (rnd)
  );

  f2i_pack u_pack (
    .r        (rnd),
    .dst_wide (dst_wide),
    .value    (value),
    .invalid  (inv_c),
    .overflow (ovf_c),
    .inexact  (inx_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      result        <= '0;
      flag_invalid  <= 1'b0;
      flag_overflow <= 1'b0;
      flag_inexact  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result        <= value;
        flag_invalid  <= inv_c;
        flag_overflow <= ovf_c;
        flag_inexact  <= inx_c;
      end
    end
  end
endmodule

// File: rtl/f2i_convert_checker.sv
module f2i_convert_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [63:0] operand,
  input logic        fmt_dbl,
  input logic        dst_wide,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        flag_invalid,
  input logic        flag_overflow,
  input logic        flag_inexact
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(flag_invalid) && $stable(flag_inexact)));
  assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dst_wide) |=> (result[63:32] == 32'h0));
  assert_dbl_special_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt_dbl && (&operand[62:52])) |=> (flag_invalid && !flag_overflow));
  assert_sgl_special_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fmt_dbl && (&operand[30:23])) |=> (flag_invalid && !flag_overflow));
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    flag_overflow |-> flag_invalid);
  assert_wide_sentinel_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_wide) |=> (!flag_invalid || result == 64'h7FFF_FFFF_FFFF_FFFF));
  assert_narrow_sentinel_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dst_wide) |=> (!flag_invalid || result == 64'h0000_0000_7FFF_FFFF));
  assert_inexact_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    flag_inexact |-> !flag_invalid);
endmodule

bind f2i_convert f2i_convert_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .operand       (operand),
  .fmt_dbl       (fmt_dbl),
  .dst_wide      (dst_wide),
  .out_valid     (out_valid),
  .result        (result),
  .flag_invalid  (flag_invalid),
  .flag_overflow (flag_overflow),
  .flag_inexact  (flag_inexact)
);

// File: tb/f2i_convert_tb.sv
module f2i_convert_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] operand = '0;
  logic        fmt_dbl = 1'b0;
  logic        dst_wide = 1'b0;
  logic [1:0]  rmode = 2'd0;
  logic        out_valid;
  logic [63:0] result;
  logic        flag_invalid, flag_overflow, flag_inexact;
  int          n_checks = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  f2i_convert u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
    .fmt_dbl(fmt_dbl), .dst_wide(dst_wide), .rmode(rmode),
    .out_valid(out_valid), .result(result), .flag_invalid(flag_invalid),
    .flag_overflow(flag_overflow), .flag_inexact(flag_inexact)
  );

  localparam logic [63:0] SENT_W = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] SENT_N = 64'h0000_0000_7FFF_FFFF;

  task automatic check(input string tag, input logic [63:0] er, input logic ei, eo, ex);
    n_checks++;
    if (!out_valid || result !== er || flag_invalid !== ei ||
        flag_overflow !== eo || flag_inexact !== ex) begin
      n_fail++;
      $display("FAIL %s: got v=%0b r=%h i%0b o%0b x%0b, expected v=1 r=%h i%0b o%0b x%0b",
               tag, out_valid, result, flag_invalid, flag_overflow, flag_inexact,
               er, ei, eo, ex);
    end
  endtask

  task automatic drive(input logic [63:0] op, input logic dbl, wide, input logic [1:0] rm);
    @(negedge clk);
    operand = op; fmt_dbl = dbl; dst_wide = wide; rmode = rm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic vec(input string tag, input logic [63:0] op, input logic dbl, wide,
                     input logic [1:0] rm, input logic [63:0] er, input logic ei, eo, ex);
    drive(op, dbl, wide, rm);
    check(tag, er, ei, eo, ex);
  endtask

  // reference model built on real arithmetic
  task automatic model(input logic [63:0] op, input logic dbl, wide, input logic [1:0] rm,
                       output logic [63:0] er, output logic ei, eo, ex);
    real    v, fr, two63;
    longint fl, r;
    logic   special;
    int     e;
    two63 = 2.0 ** 63;
    if (dbl) begin
      special = (op[62:52] == 11'h7FF);
      v = $bitstoreal(op);
    end else begin
      e = int'(op[30:23]);
      special = (e == 255);
      if (e == 0) v = real'(op[22:0]) * (2.0 ** (-149));
      else        v = (1.0 + real'(op[22:0]) * (2.0 ** (-23))) * (2.0 ** (e - 127));
      if (op[31]) v = -v;
    end
    er = wide ? SENT_W : SENT_N; ei = 1'b1; eo = 1'b0; ex = 1'b0;
    if (special) return;
    eo = 1'b1;
    if (v >= two63 || v < -two63) return;
    fl = longint'(v);
    if (real'(fl) > v) fl = fl - 1;
    fr = v - real'(fl);
    r = fl;
    case (rm)
      2'd0: if (fr > 0.5 || (fr == 0.5 && fl[0])) r = fl + 1;
      2'd1: if (v < 0.0 && fr > 0.0) r = fl + 1;
      2'd2: if (fr > 0.0) r = fl + 1;
      default: r = fl;
    endcase
    if (!wide && (r > 64'sd2147483647 || r < -64'sd2147483648)) return;
    ei = 1'b0; eo = 1'b0; ex = (fr != 0.0);
    er = wide ? r : {32'h0, r[31:0]};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] er, op;
    logic        ei, eo, ex;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check_reset: begin
      n_checks++;
      if (out_valid !== 1'b0 || result !== 64'h0 || flag_invalid !== 1'b0 ||
          flag_overflow !== 1'b0 || flag_inexact !== 1'b0) begin
        n_fail++;
        $display("FAIL R11: got v=%0b r=%h flags=%0b%0b%0b, expected all zero",
                 out_valid, result, flag_invalid, flag_overflow, flag_inexact);
      end
    end
    rst = 1'b0;

    vec("R4 nearest 1.5",      64'h3FF8_0000_0000_0000, 1, 1, 0, 64'd2, 0, 0, 1);
    vec("R4 nearest tie 2.5",  64'h4004_0000_0000_0000, 1, 1, 0, 64'd2, 0, 0, 1);
    vec("R4 nearest tie -2.5", 64'hC004_0000_0000_0000, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 1);
    vec("R3 narrow -2.5 zero", 64'hC004_0000_0000_0000, 1, 0, 1, 64'h0000_0000_FFFF_FFFE, 0, 0, 1);
    vec("R2 single upper junk", 64'hA5A5_A5A5_4020_0000, 0, 1, 2, 64'd3, 0, 0, 1);
    vec("R4 mode per op, up",   64'h4004_0000_0000_0000, 1, 1, 2, 64'd3, 0, 0, 1);
    vec("R4 mode per op, down", 64'h4004_0000_0000_0000, 1, 1, 3, 64'd2, 0, 0, 1);
    vec("R9 -0.75 up to zero",  64'h0000_0000_BF40_0000, 0, 0, 2, 64'd0, 0, 0, 1);
    vec("R9 -0.3 up to zero",   64'hBFD3_3333_3333_3333, 1, 1, 2, 64'd0, 0, 0, 1);
    vec("R4 -0.75 down",        64'h0000_0000_BF40_0000, 0, 0, 3, 64'h0000_0000_FFFF_FFFF, 0, 0, 1);
    vec("R6 single 2^31 narrow", 64'h0000_0000_4F00_0000, 0, 0, 0, SENT_N, 1, 1, 0);
    vec("R10 single -2^31",     64'h0000_0000_CF00_0000, 0, 0, 0, 64'h0000_0000_8000_0000, 0, 0, 0);
    vec("R10 double -2^63",     64'hC3E0_0000_0000_0000, 1, 1, 1, 64'h8000_0000_0000_0000, 0, 0, 0);
    vec("R6 double 2^63 wide",  64'h43E0_0000_0000_0000, 1, 1, 1, SENT_W, 1, 1, 0);
    vec("R7 negative sentinel", 64'hC3E0_0000_0000_0000, 1, 0, 1, SENT_N, 1, 1, 0);
    vec("R6 tie rounds past edge", 64'h41DF_FFFF_FFE0_0000, 1, 0, 0, SENT_N, 1, 1, 0);
    vec("R8 edge truncated",    64'h41DF_FFFF_FFE0_0000, 1, 0, 1, SENT_N, 0, 0, 1);
    vec("R5 negative NaN",      64'hFFF8_0000_0000_0001, 1, 1, 0, SENT_W, 1, 0, 0);
    vec("R5 minus infinity",    64'hFFF0_0000_0000_0000, 1, 0, 3, SENT_N, 1, 0, 0);
    vec("R5 single NaN",        64'h0000_0000_FFC0_0000, 0, 1, 1, SENT_W, 1, 0, 0);

    // R1: outputs hold while idle
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || result !== SENT_W || flag_invalid !== 1'b1) begin
      n_fail++;
      $display("FAIL R1: got v=%0b r=%h i=%0b, expected v=0 r=%h i=1",
               out_valid, result, flag_invalid, SENT_W);
    end

    for (int i = 0; i < 3000; i++) begin
      logic dbl, wide;
      logic [1:0] rm;
      int cls, ex_f;
      dbl = 1'($urandom); wide = 1'($urandom); rm = 2'($urandom);
      cls = int'($urandom % 16);
      op = {$urandom, $urandom};
      if (dbl) begin
        ex_f = (cls == 0) ? 2047 : (cls == 1) ? 0 : 1020 + int'($urandom % 70);
        op[62:52] = 11'(ex_f);
        if (cls == 2) op[51:0] = op[51:0] & (52'hF_FFFF_FFFF_FFFF << ($urandom % 53));
      end else begin
        ex_f = (cls == 0) ? 255 : (cls == 1) ? 0 : 124 + int'($urandom % 70);
        op[30:23] = 8'(ex_f);
        if (cls == 2) op[22:0] = op[22:0] & (23'h7F_FFFF << ($urandom % 24));
      end
      model(op, dbl, wide, rm, er, ei, eo, ex);
      drive(op, dbl, wide, rm);
      check("R2 R3 R4 R6 R8 random", er, ei, eo, ex);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule